// File: doc/BRIEF.md
# Up-Counting Timer with Selectable Trigger Output

This block is a general-purpose up-counter driven by a programmable clock divider. It counts from zero up to a reload value and then wraps. Each wrap is an update event. At an update event the reload value and the divider value in use are refreshed from the values software last wrote. Software can also request an immediate update through a self-clearing strobe bit. That strobe restarts the count and loads the pending values at once.

A single registered trigger line, `trgOut`, carries one of eight internal events to neighbouring blocks. A 3-bit field selects the event:

| Code | Event on `trgOut` |
|---|---|
| 0 | Software restart strobe |
| 1 | Counter enable |
| 2 | Update pulse |
| 3 | Channel-1 compare-flag pulse |
| 4 to 7 | Output-compare reference 1 to 4 |

In update mode, one timer can act as a divider for another. The compare logic that produces the reference levels and the compare flag lives outside this block; those signals arrive as inputs.

The register port has four addresses:

| Address | Contents |
|---|---|
| 0 | Control |
| 1 | Divider value |
| 2 | Reload value |
| 3 | Live count (read only) |

Writes take effect on the clock edge. Reads are combinational from `rdAddr`.

Top module: `trigTimer`

## Requirements
- R1: After reset, `trgOut` is 0, and all four read addresses return 0.
- R2: The control word at address 0 holds these fields: bit 0 is count enable, bit 1 is reload buffering, bit 2 is the restart strobe, and bits 6:4 are the trigger select. The restart strobe always reads back as 0. The other control fields, the divider value and the reload value read back as written.
- R3: While enabled, the count advances once every divider+1 clocks. A newly written divider value is used only from the next update event or restart.
- R4: The count runs 0, 1, ..., reload and then wraps to 0, so the period is reload+1 steps. If a step starts with the count at or above the active reload, that step wraps to 0 and is an update event.
- R5: With count enable at 0, the count holds its value.
- R6: With buffering on, a written reload value becomes active only at an update event or a restart.
- R7: With buffering off, a written reload value is active from the clock after the write.
- R8: Writing control with bit 2 set zeroes the count and the divider phase at that write edge, and loads the pending divider and reload values.
- R9: With select 0, `trgOut` is 1 for the single clock after a restart write and 0 otherwise.
- R10: With select 1, `trgOut` equals the count enable of one clock earlier.
- R11: With select 2, `trgOut` is 1 for one clock after each update event, whether the event comes from a wrap or from a restart.
- R12: With select 3, `trgOut` repeats `cmpFlagSet` one clock later, so each one-clock flag pulse gives one one-clock trigger pulse.
- R13: With select 4+n (n = 0 to 3), `trgOut` repeats `ocRef[n]` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | DATA_W | Read data, combinational |
| ocRef | input | 4 | Output-compare reference levels 1 to 4 |
| cmpFlagSet | input | 1 | Channel-1 compare-flag set pulse |
| trgOut | output | 1 | Selected trigger output, registered |

## Verification
The bench builds the timer with `DATA_W = 8` and `PSC_W = 4`. These narrow widths keep the control fields intact while letting a short run reach the following cases:

- several complete wraps with small reload values;
- a divider change that is held back until a restart;
- reload changes, with and without buffering, landing in the middle of a period.

The bench also steps the trigger select through all eight codes. For each code it checks where the one-clock pulses land relative to the write, flag and reference stimulus.

// File: rtl/trigTimerPkg.sv
package trigTimerPkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd3;

  // Control word field positions
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_BUF_BIT  = 1;
  localparam int CTL_RST_BIT  = 2;
  localparam int CTL_SEL_LSB  = 4;
  localparam int SEL_W        = 3;
  localparam int CTL_MIN_W    = CTL_SEL_LSB + SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_RESTART = 3'd0,
    SEL_ENABLE  = 3'd1,
    SEL_UPDATE  = 3'd2,
    SEL_CMP     = 3'd3,
    SEL_REF1    = 3'd4,
    SEL_REF2    = 3'd5,
    SEL_REF3    = 3'd6,
    SEL_REF4    = 3'd7
  } trgSel_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic cntEn;
    logic bufEn;
    logic forceUpd;
  } ctrlStrobes_t;

endpackage

// File: rtl/trigTimerCtrl.sv
module trigTimerCtrl
  import trigTimerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              updEvt,
  input  logic [3:0]        ocRef,
  input  logic              cmpFlagSet,
  output ctrlStrobes_t      strb,
  output logic [PSC_W-1:0]  pscVal,
  output logic [DATA_W-1:0] arrVal,
  output logic              trgOut
);

  logic    cenQ;
  logic    bufQ;
  trgSel_e selQ;
  logic    trgNext;

  logic wrCtrl;
  logic wrDiv;
  logic wrReload;

  assign wrCtrl   = wrEn && (wrAddr == ADDR_CTRL);
  assign wrDiv    = wrEn && (wrAddr == ADDR_DIV);
  assign wrReload = wrEn && (wrAddr == ADDR_RELOAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cenQ   <= 1'b0;
      bufQ   <= 1'b0;
      selQ   <= SEL_RESTART;
      pscVal <= '0;
      arrVal <= '0;
    end else begin
      if (wrCtrl) begin
        cenQ <= wrData[CTL_EN_BIT];
        bufQ <= wrData[CTL_BUF_BIT];
        selQ <= trgSel_e'(wrData[CTL_SEL_LSB +: SEL_W]);
      end
      if (wrDiv)    pscVal <= wrData[PSC_W-1:0];
      if (wrReload) arrVal <= wrData;
    end
  end

  always_comb begin
    strb.cntEn    = cenQ;
    strb.bufEn    = bufQ;
    strb.forceUpd = wrCtrl && wrData[CTL_RST_BIT];
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: begin
        rdData[CTL_EN_BIT]              = cenQ;
        rdData[CTL_BUF_BIT]             = bufQ;
        rdData[CTL_SEL_LSB +: SEL_W]    = selQ;
      end
      ADDR_DIV:    rdData[PSC_W-1:0] = pscVal;
      ADDR_RELOAD: rdData = arrVal;
      default:     rdData = cntVal;
    endcase
  end

  always_comb begin
    case (selQ)
      SEL_RESTART: trgNext = strb.forceUpd;
      SEL_ENABLE:  trgNext = cenQ;
      SEL_UPDATE:  trgNext = updEvt || strb.forceUpd;
      SEL_CMP:     trgNext = cmpFlagSet;
      default:     trgNext = ocRef[selQ[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) trgOut <= 1'b0;
    else       trgOut <= trgNext;
  end

  AST_TRG_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == SEL_RESTART) |=> (trgOut == $past(strb.forceUpd))); // R9
  AST_TRG_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == SEL_ENABLE) |=> (trgOut == $past(cenQ))); // R10
  AST_TRG_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    ((selQ == SEL_UPDATE) && updEvt) |=> trgOut); // R11
  AST_TRG_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == SEL_CMP) |=> (trgOut == $past(cmpFlagSet))); // R12
  AST_TRG_REF: assert property (@(posedge clk) disable iff (!rstN)
    selQ[2] |=> (trgOut == $past(ocRef[selQ[1:0]]))); // R13

endmodule

// File: rtl/trigTimerDatapath.sv
module trigTimerDatapath
  import trigTimerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [PSC_W-1:0]  pscVal,
  input  logic [DATA_W-1:0] arrVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              updEvt
);

  logic [PSC_W-1:0]  pscCnt;
  logic [PSC_W-1:0]  pscAct;
  logic [DATA_W-1:0] arrAct;
  logic              tick;
  logic              reach;

  assign tick   = strb.cntEn && (pscCnt == pscAct);
  assign reach  = (cntVal >= arrAct);
  assign updEvt = tick && reach;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
      pscAct <= '0;
      arrAct <= '0;
      cntVal <= '0;
    end else if (strb.forceUpd) begin
      pscCnt <= '0;
      cntVal <= '0;
      pscAct <= pscVal;
      arrAct <= arrVal;
    end else begin
      if (strb.cntEn) pscCnt <= tick ? '0 : pscCnt + 1'b1;
      if (tick)       cntVal <= reach ? '0 : cntVal + 1'b1;
      if (updEvt) begin
        pscAct <= pscVal;
        arrAct <= arrVal;
      end else if (!strb.bufEn) begin
        arrAct <= arrVal;
      end
    end
  end

  AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pscCnt <= pscAct); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> (cntVal == '0)); // R4
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntEn && !strb.forceUpd) |=> $stable(cntVal)); // R5
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bufEn && !updEvt && !strb.forceUpd) |=> $stable(arrAct)); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceUpd |=> (cntVal == '0 && pscCnt == '0)); // R8

endmodule

// File: rtl/trigTimer.sv
module trigTimer
  import trigTimerPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [3:0]        ocRef,
  input  logic              cmpFlagSet,
  output logic              trgOut
);

  initial begin
    assert (DATA_W >= CTL_MIN_W && PSC_W <= DATA_W && PSC_W > 0)
      else $error("trigTimer: width parameters out of range");
  end

  ctrlStrobes_t      strb;
  logic [PSC_W-1:0]  pscVal;
  logic [DATA_W-1:0] arrVal;
  logic [DATA_W-1:0] cntVal;
  logic              updEvt;

  trigTimerCtrl #(.DATA_W(DATA_W), .PSC_W(PSC_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .cntVal     (cntVal),
    .updEvt     (updEvt),
    .ocRef      (ocRef),
    .cmpFlagSet (cmpFlagSet),
    .strb       (strb),
    .pscVal     (pscVal),
    .arrVal     (arrVal),
    .trgOut     (trgOut)
  );

  trigTimerDatapath #(.DATA_W(DATA_W), .PSC_W(PSC_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pscVal (pscVal),
    .arrVal (arrVal),
    .cntVal (cntVal),
    .updEvt (updEvt)
  );

endmodule

// File: tb/test_trigTimer.sv
module test_trigTimer;

  localparam int DATA_W = 8;
  localparam int PSC_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [1:0]        rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [3:0]        ocRef = '0;
  logic              cmpFlagSet = 1'b0;
  logic              trgOut;

  trigTimer #(.DATA_W(DATA_W), .PSC_W(PSC_W)) i_trigTimer (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .rdAddr, .rdData,
    .ocRef, .cmpFlagSet, .trgOut
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    isTrg;
    int    addr;
    int    exp;
    string tag;
  } expItem_t;

  expItem_t sb[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Scoreboard driver side
  task automatic expectAt(input int at, input bit isTrg, input int addr,
                          input int exp, input string tag);
    expItem_t it;
    it.at = at; it.isTrg = isTrg; it.addr = addr; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = DATA_W'(d);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int ctl(input int sel, input int rst, input int bufEn, input int en);
    return (sel << 4) | (rst << 2) | (bufEn << 1) | en;
  endfunction

  // Scoreboard monitor side
  initial begin
    forever begin
      @(negedge clk);
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at <= cyc) begin
          int act;
          if (sb[i].isTrg) act = int'(trgOut);
          else begin
            rdAddr = 2'(sb[i].addr);
            #1;
            act = int'(rdData);
          end
          nChecks++;
          if (sb[i].at < cyc || act != sb[i].exp) begin
            nFails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d",
                     sb[i].tag, sb[i].at, act, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int w;
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectAt(cyc + 1, 1, 0, 0, "R1 trg");
    for (int a = 0; a < 4; a++) expectAt(cyc + 1, 0, a, 0, "R1 reg");
    waitTo(cyc + 2);

    // R4 / R11: divider 0, reload 4, update select
    wr(1, 0);
    wr(2, 4);
    wr(0, ctl(2, 0, 0, 0));
    wr(0, ctl(2, 1, 0, 1));
    w = cyc;
    for (int k = 1; k <= 12; k++) begin
      expectAt(w + k, 0, 3, k % 5, "R4 count");
      expectAt(w + k, 1, 0, (k % 5 == 0) ? 1 : 0, "R11 update pulse");
    end
    expectAt(w + 1, 0, 0, ctl(2, 0, 0, 1), "R2 restart bit reads 0");
    expectAt(w + 1, 0, 2, 4, "R2 reload readback");
    waitTo(w + 13);

    // R3: divider is held back until restart
    wr(1, 2);
    expectAt(cyc + 1, 0, 3, (cyc + 1 - w) % 5, "R3 divider buffered");
    expectAt(cyc + 1, 0, 1, 2, "R2 divider readback");
    waitTo(cyc + 2);
    wr(0, ctl(2, 1, 0, 1));
    w = cyc;
    for (int k = 1; k <= 9; k++) expectAt(w + k, 0, 3, (k / 3) % 5, "R3 divide by 3");
    waitTo(w + 10);

    // R6: buffered reload change mid-period
    wr(1, 0);
    wr(2, 9);
    wr(0, ctl(2, 1, 1, 1));
    w = cyc;
    expectAt(w + 4, 0, 2, 3, "R2 reload shadow readback");
    expectAt(w + 8, 0, 3, 8, "R6 old reload active");
    expectAt(w + 9, 0, 3, 9, "R6 old reload active");
    expectAt(w + 9, 1, 0, 0, "R11 no pulse");
    expectAt(w + 10, 0, 3, 0, "R6 wrap at old reload");
    expectAt(w + 10, 1, 0, 1, "R11 pulse at wrap");
    expectAt(w + 13, 0, 3, 3, "R6 new reload");
    expectAt(w + 14, 0, 3, 0, "R6 new period");
    waitTo(w + 2);
    wr(2, 3);
    waitTo(w + 15);

    // R7: unbuffered reload change, count already above it
    wr(2, 9);
    wr(0, ctl(2, 1, 0, 1));
    w = cyc;
    expectAt(w + 5, 0, 3, 5, "R7 before change");
    expectAt(w + 6, 0, 3, 6, "R7 one step");
    expectAt(w + 7, 0, 3, 0, "R4 wrap above reload");
    expectAt(w + 10, 0, 3, 3, "R7 new reload");
    expectAt(w + 11, 0, 3, 0, "R7 new period");
    waitTo(w + 4);
    wr(2, 3);
    waitTo(w + 12);

    // R10 / R5: enable select and hold
    wr(2, 200);
    wr(0, ctl(1, 1, 0, 1));
    w = cyc;
    expectAt(w + 1, 1, 0, 1, "R10 enable high");
    expectAt(w + 6, 1, 0, 1, "R10 enable lag");
    expectAt(w + 7, 1, 0, 0, "R10 enable low");
    expectAt(w + 6, 0, 3, 6, "R5 count at stop");
    expectAt(w + 9, 0, 3, 6, "R5 count held");
    waitTo(w + 5);
    wr(0, ctl(1, 0, 0, 0));
    waitTo(w + 10);

    // R9 / R8: restart select
    wr(0, ctl(0, 0, 0, 1));
    expectAt(cyc + 2, 1, 0, 0, "R9 idle low");
    waitTo(cyc + 4);
    c0 = cyc;
    expectAt(c0 + 1, 1, 0, 1, "R9 restart pulse");
    expectAt(c0 + 2, 1, 0, 0, "R9 pulse ends");
    expectAt(c0 + 1, 0, 3, 0, "R8 count zeroed");
    expectAt(c0 + 2, 0, 3, 1, "R8 count restarts");
    wr(0, ctl(0, 1, 0, 1));
    waitTo(c0 + 3);

    // R12: compare pulse select
    wr(0, ctl(3, 0, 0, 0));
    c0 = cyc;
    expectAt(c0 + 1, 1, 0, 0, "R12 idle");
    waitTo(c0 + 1);
    expectAt(c0 + 2, 1, 0, 1, "R12 pulse");
    expectAt(c0 + 3, 1, 0, 0, "R12 pulse ends");
    cmpFlagSet = 1'b1;
    @(negedge clk);
    cmpFlagSet = 1'b0;
    waitTo(c0 + 4);

    // R13: each reference select
    for (int n = 0; n < 4; n++) begin
      wr(0, ctl(4 + n, 0, 0, 0));
      c0 = cyc;
      ocRef = 4'(1 << n);
      expectAt(c0 + 1, 1, 0, 1, "R13 ref high");
      @(negedge clk);
      ocRef = 4'(~(1 << n));
      expectAt(c0 + 2, 1, 0, 0, "R13 ref low");
      @(negedge clk);
      ocRef = 4'h0;
    end
    waitTo(cyc + 3);

    if (sb.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule